// File: doc/BRIEF.md
# 16-bit ALU with Status Flags

This block combines a 16-bit arithmetic and logic unit with a small processor status register. Two operands and an operation code go in, and a 16-bit result comes out in the same cycle. On a clock edge with the update enable high, the carry and zero flags are captured from that operation. The supported operations are add, subtract, AND, OR, XOR, one-bit logical shifts and one-bit rotates. The stored zero flag is what a branch-if-not-equal decision reads.

The status word can be driven onto the data bus and loaded back from it, so microcode can push flags to a stack and pull them off again. The interrupt-disable flag has its own write strobe, so the arithmetic flags are not touched when it changes. The active-low system reset is inverted inside the block, and the inverted signal clears the register asynchronously.

Top module: `alu_flags`

## Requirements
- R1: While `rst_n` is low, `carry`, `zero` and `int_dis` are 0.
- R2: Op 0 (add) gives `result` = a + b mod 2^16. With `alu_en` high, `carry` takes the carry out of bit 15 at the edge.
- R3: Op 1 (subtract) gives `result` = a + ~b + 1 mod 2^16. With `alu_en` high, `carry` becomes 1 exactly when a >= b (unsigned), which means no borrow.
- R4: Ops 2 (AND), 3 (OR) and 4 (XOR) give the bitwise result and leave `carry` unchanged even with `alu_en` high.
- R5: Op 5 (shift left) and op 6 (shift right) move the operand by one bit and fill with 0. With `alu_en` high, `carry` takes the bit shifted out (a[15] for left, a[0] for right).
- R6: Op 7 (rotate left) and op 8 (rotate right) move the bit shifted out into the vacated end. With `alu_en` high, that bit is also copied to `carry`.
- R7: For ops 0 to 8 with `alu_en` high, `zero` becomes 1 exactly when all 16 result bits are 0.
- R8: With `alu_en`, `int_we` and `flag_ld` all low, none of the flags changes.
- R9: `int_we` sets `int_dis` to `int_val` and does not by itself change `carry` or `zero`.
- R10: With `flag_rd` high, `bus_out` = {13'b0, int_dis, zero, carry} (bit 0 carry, bit 1 zero, bit 2 interrupt-disable) and `bus_oe` is 1. Otherwise `bus_out` is 0 and `bus_oe` is 0.
- R11: `flag_ld` loads carry from `flag_in[0]`, zero from `flag_in[1]` and interrupt-disable from `flag_in[2]`. It takes precedence over `alu_en` and `int_we` in the same cycle.
- R12: If `alu_en` and `int_we` are high in the same cycle without `flag_ld`, both take effect.
- R13: Op codes 9 to 15 give `result` = a and leave every flag unchanged, even with `alu_en` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low system reset |
| op | input | 4 | Operation code |
| a | input | 16 | First operand |
| b | input | 16 | Second operand |
| alu_en | input | 1 | Capture carry and zero from this operation |
| result | output | 16 | Combinational ALU result |
| int_we | input | 1 | Interrupt-disable write strobe |
| int_val | input | 1 | New interrupt-disable value |
| flag_rd | input | 1 | Drive the status word onto the bus |
| flag_ld | input | 1 | Load the status word from the bus |
| flag_in | input | 3 | Low three bits of the data bus, used for a load |
| bus_out | output | 16 | Status word driven toward the bus |
| bus_oe | output | 1 | Bus drive enable |
| carry | output | 1 | Carry flag |
| zero | output | 1 | Zero flag |
| int_dis | output | 1 | Interrupt-disable flag |

## Verification
Three sources can write the status register in the same cycle: an ALU flag update, the interrupt strobe and a bus load. The bench drives an add that produces carry and zero together with an interrupt write, and expects all three flags to change. It then drives a bus load together with both of the other writers, and expects exactly the bus value. A bus read in the same cycle as an ALU update must show the flags as they were before that edge.

// File: rtl/alu_flags.sv
module alu_flags #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [3:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         alu_en,
  output logic [W-1:0] result,
  input  logic         int_we,
  input  logic         int_val,
  input  logic         flag_rd,
  input  logic         flag_ld,
  input  logic [2:0]   flag_in,
  output logic [W-1:0] bus_out,
  output logic         bus_oe,
  output logic         carry,
  output logic         zero,
  output logic         int_dis
);
  localparam logic [3:0] OP_ADD = 4'd0, OP_SUB = 4'd1, OP_AND = 4'd2,
                         OP_OR  = 4'd3, OP_XOR = 4'd4, OP_SHL = 4'd5,
                         OP_SHR = 4'd6, OP_ROL = 4'd7, OP_ROR = 4'd8;

  logic         rst;
  logic [W:0]   sum;
  logic         cout;
  logic         upd;

  assign rst = ~rst_n;

  always_comb begin
    sum    = '0;
    result = a;
    cout   = carry;
    upd    = 1'b1;
    case (op)
      OP_ADD: begin
        sum    = {1'b0, a} + {1'b0, b};
        result = sum[W-1:0];
        cout   = sum[W];
      end
      OP_SUB: begin
        sum    = {1'b0, a} + {1'b0, ~b} + {{W{1'b0}}, 1'b1};
        result = sum[W-1:0];
        cout   = sum[W];
      end
      OP_AND: result = a & b;
      OP_OR:  result = a | b;
      OP_XOR: result = a ^ b;
      OP_SHL: begin result = {a[W-2:0], 1'b0};   cout = a[W-1]; end
      OP_SHR: begin result = {1'b0, a[W-1:1]};   cout = a[0];   end
      OP_ROL: begin result = {a[W-2:0], a[W-1]}; cout = a[W-1]; end
      OP_ROR: begin result = {a[0], a[W-1:1]};   cout = a[0];   end
      default: upd = 1'b0;
    endcase
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      carry   <= 1'b0;
      zero    <= 1'b0;
      int_dis <= 1'b0;
    end else if (flag_ld) begin
      carry   <= flag_in[0];
      zero    <= flag_in[1];
      int_dis <= flag_in[2];
    end else begin
      if (alu_en && upd) begin
        carry <= cout;
        zero  <= (result == '0);
      end
      if (int_we) int_dis <= int_val;
    end
  end

  assign bus_oe  = flag_rd;
  assign bus_out = flag_rd ? {{(W-3){1'b0}}, int_dis, zero, carry} : '0;
endmodule

// File: rtl/alu_flags_chk.sv
module alu_flags_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic [3:0]   op,
  input logic         alu_en,
  input logic [W-1:0] result,
  input logic         int_we,
  input logic         int_val,
  input logic         flag_rd,
  input logic         flag_ld,
  input logic [2:0]   flag_in,
  input logic [W-1:0] bus_out,
  input logic         bus_oe,
  input logic         carry,
  input logic         zero,
  input logic         int_dis
);
  assert_load_R11: assert property (@(posedge clk) disable iff (!rst_n)
    flag_ld |=> {int_dis, zero, carry} == $past(flag_in));

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!alu_en && !int_we && !flag_ld) |=> $stable({int_dis, zero, carry}));

  assert_int_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (int_we && !flag_ld) |=> int_dis == $past(int_val));

  assert_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_en && !flag_ld && op <= 4'd8) |=> zero == ($past(result) == '0));

  assert_logic_carry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_ld && op >= 4'd2 && op <= 4'd4) |=> $stable(carry));

  assert_unused_op_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_ld && !int_we && op > 4'd8) |=> $stable({int_dis, zero, carry}));

  assert_bus_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_oe == flag_rd) && (bus_out[W-1:3] == '0) && (flag_rd || bus_out == '0));
endmodule

bind alu_flags alu_flags_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .op(op), .alu_en(alu_en), .result(result),
  .int_we(int_we), .int_val(int_val), .flag_rd(flag_rd), .flag_ld(flag_ld),
  .flag_in(flag_in), .bus_out(bus_out), .bus_oe(bus_oe),
  .carry(carry), .zero(zero), .int_dis(int_dis)
);

// File: tb/tb_alu_flags.sv
module tb_alu_flags;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  op = '0;
  logic [15:0] a = '0, b = '0;
  logic        alu_en = 0, int_we = 0, int_val = 0, flag_rd = 0, flag_ld = 0;
  logic [2:0]  flag_in = '0;
  logic [15:0] result, bus_out;
  logic        bus_oe, carry, zero, int_dis;

  int checks = 0, errors = 0;
  logic done = 1'b0;
  logic mc = 0, mz = 0, mi = 0;

  typedef struct {
    logic [15:0] res;
    logic [15:0] bus;
    logic        oe;
    logic [2:0]  flg;
    string       tag;
  } item_t;
  item_t q[$];

  always #4 clk = ~clk;

  alu_flags dut (
    .clk(clk), .rst_n(rst_n), .op(op), .a(a), .b(b), .alu_en(alu_en),
    .result(result), .int_we(int_we), .int_val(int_val), .flag_rd(flag_rd),
    .flag_ld(flag_ld), .flag_in(flag_in), .bus_out(bus_out), .bus_oe(bus_oe),
    .carry(carry), .zero(zero), .int_dis(int_dis)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [3:0] o, input logic [15:0] x, input logic [15:0] y,
                      input logic en, input logic iw, input logic iv,
                      input logic rd, input logic ld, input logic [2:0] fi,
                      input string tag);
    item_t it;
    logic [16:0] s;
    logic [15:0] r;
    logic co, up;
    @(negedge clk);
    op = o; a = x; b = y; alu_en = en; int_we = iw; int_val = iv;
    flag_rd = rd; flag_ld = ld; flag_in = fi;
    r = x; co = mc; up = 1'b1;
    case (o)
      4'd0: begin s = {1'b0, x} + {1'b0, y}; r = s[15:0]; co = s[16]; end
      4'd1: begin r = x - y; co = (x >= y); end
      4'd2: r = x & y;
      4'd3: r = x | y;
      4'd4: r = x ^ y;
      4'd5: begin r = x << 1; co = x[15]; end
      4'd6: begin r = x >> 1; co = x[0]; end
      4'd7: begin r = (x << 1) | (x >> 15); co = x[15]; end
      4'd8: begin r = (x >> 1) | (x << 15); co = x[0]; end
      default: up = 1'b0;
    endcase
    it.res = r;
    it.bus = rd ? {13'b0, mi, mz, mc} : 16'h0;
    it.oe  = rd;
    if (ld) begin
      mc = fi[0]; mz = fi[1]; mi = fi[2];
    end else begin
      if (en && up) begin mc = co; mz = (r == 16'h0); end
      if (iw) mi = iv;
    end
    it.flg = {mi, mz, mc};
    it.tag = tag;
    q.push_back(it);
  endtask

  initial begin : monitor
    item_t it;
    forever begin
      @(negedge clk);
      #2;
      if (q.size() > 0) begin
        it = q.pop_front();
        chk({it.tag, " result"}, result, it.res);
        chk({it.tag, " bus"}, {bus_out[15:1], bus_out[0]}, it.bus);
        chk({it.tag, " oe"}, {15'b0, bus_oe}, {15'b0, it.oe});
        @(posedge clk);
        #1;
        chk({it.tag, " flags"}, {13'b0, int_dis, zero, carry}, {13'b0, it.flg});
      end
    end
  end

  initial begin : watchdog
    #(8 * 20000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset flags", {13'b0, int_dis, zero, carry}, 16'h0);
    chk("R1 reset bus", bus_out, 16'h0);
    @(negedge clk); rst_n = 1'b1;

    step(4'd0, 16'hFFFF, 16'h0001, 1, 0, 0, 0, 0, 3'b0, "R2 add wrap R7");
    step(4'd0, 16'h1234, 16'h1111, 1, 0, 0, 1, 0, 3'b0, "R2 add R10");
    step(4'd1, 16'h0005, 16'h0003, 1, 0, 0, 0, 0, 3'b0, "R3 sub nb");
    step(4'd1, 16'h0003, 16'h0005, 1, 0, 0, 0, 0, 3'b0, "R3 sub borrow");
    step(4'd1, 16'h4242, 16'h4242, 1, 0, 0, 0, 0, 3'b0, "R3 sub eq R7");
    step(4'd2, 16'hF0F0, 16'h0F0F, 1, 0, 0, 0, 0, 3'b0, "R4 and zero");
    step(4'd3, 16'hA000, 16'h0005, 1, 0, 0, 0, 0, 3'b0, "R4 or");
    step(4'd4, 16'hFFFF, 16'h0F0F, 1, 0, 0, 1, 0, 3'b0, "R4 xor");
    step(4'd5, 16'h8001, 16'h0, 1, 0, 0, 0, 0, 3'b0, "R5 shl");
    step(4'd6, 16'h0001, 16'h0, 1, 0, 0, 0, 0, 3'b0, "R5 shr zero");
    step(4'd6, 16'h8000, 16'h0, 1, 0, 0, 0, 0, 3'b0, "R5 shr fill");
    step(4'd7, 16'h8000, 16'h0, 1, 0, 0, 0, 0, 3'b0, "R6 rol");
    step(4'd8, 16'h0001, 16'h0, 1, 0, 0, 0, 0, 3'b0, "R6 ror");
    step(4'd7, 16'h4000, 16'h0, 1, 0, 0, 0, 0, 3'b0, "R6 rol nc");
    step(4'd0, 16'h0000, 16'h0000, 0, 0, 0, 1, 0, 3'b0, "R8 hold");
    step(4'd2, 16'h0000, 16'h0000, 0, 1, 1, 0, 0, 3'b0, "R9 int set");
    step(4'd0, 16'h0001, 16'h0001, 0, 0, 0, 1, 0, 3'b0, "R10 read");
    step(4'd0, 16'hFFFF, 16'h0001, 1, 1, 0, 1, 0, 3'b0, "R12 both");
    step(4'd0, 16'h0000, 16'h0000, 0, 0, 0, 1, 0, 3'b0, "R12 view");
    step(4'd0, 16'h0001, 16'h0001, 1, 1, 0, 0, 1, 3'b111, "R11 load wins");
    step(4'd9, 16'h0000, 16'h0000, 1, 0, 0, 1, 0, 3'b0, "R13 op9");
    step(4'd15, 16'hBEEF, 16'h1, 1, 0, 0, 1, 0, 3'b0, "R13 op15");
    step(4'd3, 16'h0, 16'h0, 0, 0, 0, 0, 1, 3'b010, "R11 load z");
    step(4'd0, 16'h0, 16'h0, 0, 0, 0, 1, 0, 3'b0, "R10 final");
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule